// File: doc/BRIEF.md
# Two-Stage UART Baud Tick Generator

This block turns a system clock into the two timing strobes a UART needs: a bit-sample tick for the receiver's oversampling logic and a baud tick that marks one bit period. The first stage divides a source clock by a 16-bit generator value and emits the sample tick. The second stage counts sample ticks and emits the baud tick once every (divider value + 1) of them. The baud rate is therefore the source clock divided by generator × (divider + 1).

The source clock is either the raw input clock or the input clock divided by eight. The divide-by-eight path is built as a clock enable, so the whole block runs on one clock. A simple write port loads the generator value, the divider value and the source-select bit. A generator value of zero holds both strobes low. A divider write below four is refused. Any write that is accepted restarts all counters, so the next period is a full one.

Top module: `baud_gen_top`

## Requirements
- R1: After reset both ticks are low, the generator value is 651 (0x28B), the divider value is 15 (0x0F) and the raw clock is selected. The first sample tick is seen 651 cycles after the last reset cycle and the first baud tick 10416 cycles after it.
- R2: With the raw clock selected and a generator value G of 1 or more, sample_tick pulses once every G cycles. With G of 2 or more each pulse is one cycle wide.
- R3: baud_tick pulses once every G × (D + 1) source periods, where D is the divider value. Each baud pulse coincides with a sample pulse.
- R4: With a generator value of zero, neither tick is ever asserted.
- R5: A divider write with data below 4 is ignored. The old divider value is kept and the counters are not restarted, so the baud period is unchanged.
- R6: When the select bit is written as 1, the source is the input clock divided by 8. The sample period becomes 8 × G cycles and the baud period becomes 8 × G × (D + 1) cycles.
- R7: An accepted write to the generator value, the divider value or the select bit restarts all counters. Counting in cycles after the write edge, the first sample tick comes after exactly one full sample period and the first baud tick after exactly one full baud period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_we | input | 1 | Write strobe for the generator value |
| gen_wdata | input | 16 | New generator value (0 stops the ticks) |
| div_we | input | 1 | Write strobe for the divider value |
| div_wdata | input | 8 | New divider value (accepted only if 4 or more) |
| src_we | input | 1 | Write strobe for the source-select bit |
| src_wdata | input | 1 | 0 selects the raw clock, 1 selects the clock divided by 8 |
| sample_tick | output | 1 | Bit-sample strobe |
| baud_tick | output | 1 | Bit-period strobe |

## Verification
The bench times the first pulse after every write. A design that failed to restart would show a short first period, or one that depends on the phase of the previous counter. It writes a divider value of 3 and confirms that the baud period does not shrink to 4 × G. A design that took the value would give that shorter period. It also checks that the divider value after a refused write still applies, which catches a design that clears the divider instead of keeping it.

The bench checks that the generator value of zero produces no pulses at all. A counter that compares against G − 1 without guarding zero would wrap and tick. It runs the divided-clock mode, where a wrong pre-divider phase shows up as a first tick that is not at 8 × G. It runs the reset defaults through to the first baud tick.

// File: rtl/baud_pkg.sv
// Package: shared widths, limits and reset values of the baud tick generator.
package baud_pkg;
    localparam int          GEN_W    = 16;
    localparam int          DIV_W    = 8;
    localparam int          DIV_MIN  = 4;
    localparam int          PREDIV   = 8;
    localparam logic [15:0] GEN_RST  = 16'h028B;
    localparam logic [7:0]  DIV_RST  = 8'h0F;
endpackage

// File: rtl/baud_prediv.sv
// Module: baud_prediv
// Produces the source enable for the divider chain. In raw mode it is high
// every cycle. In divided mode it is high once every PREDIV cycles.
// Assumes: restart clears the phase, so the first enable in divided mode
// arrives PREDIV cycles after the restart edge.
module baud_prediv #(
    parameter int PREDIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div_mode,
    output logic src_en
);
    localparam int PD_W = (PREDIV > 1) ? $clog2(PREDIV) : 1;

    logic [PD_W-1:0] ph_q;

    // Free-running phase counter, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph_q <= '0;
        end else if (ph_q == PD_W'(PREDIV - 1)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Pick the raw or divided enable.
    always_comb begin
        src_en = div_mode ? (ph_q == PD_W'(PREDIV - 1)) : 1'b1;
    end

    // In divided mode an enable is never followed at once by another.
    p_prediv_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_mode && src_en && !restart) |=> !src_en);
endmodule

// File: rtl/baud_sample_div.sv
// Module: baud_sample_div
// First stage. Counts source enables and wraps after gen of them. It emits a
// one-cycle wrap strobe towards the second stage and a registered sample tick.
// Assumes: gen == 0 means stopped. restart zeroes the count and the tick.
module baud_sample_div #(
    parameter int GEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             src_en,
    input  logic [GEN_W-1:0] gen,
    output logic             wrap,
    output logic             tick
);
    logic [GEN_W-1:0] cnt_q;

    // Wrap when the last source period of the sample period ends.
    always_comb begin
        wrap = src_en && !restart && (gen != '0) && (cnt_q == gen - 1'b1);
    end

    // Sample counter and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap) begin
                cnt_q <= '0;
            end else if (src_en && gen != '0) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The count stays below the generator value.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gen != '0) |-> (cnt_q < gen));
    // A zero generator value never lets a tick out.
    p_zero_gen_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen == '0) |-> !tick);
endmodule

// File: rtl/baud_bit_div.sv
// Module: baud_bit_div
// Second stage. It steps only on first-stage wraps and emits a registered baud
// tick when its count passes div, giving div + 1 sample periods per bit.
// Assumes: div is at least the accepted minimum. restart zeroes the state.
module baud_bit_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Count sample periods and wrap after div + 1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= step && (cnt_q == div);
            if (step) begin
                cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // The count never exceeds the divider value.
    p_bit_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div);
endmodule

// File: rtl/baud_gen_top.sv
// Module: baud_gen_top
// Holds the divisor and source-select registers and chains the pre-divider,
// the sample stage and the bit stage. An accepted write restarts every counter
// on the following cycle. A divider write below DIV_MIN is dropped.
// Assumes: at most one register is written in a cycle. If several are
// written together they all update and a single restart follows.
module baud_gen_top
    import baud_pkg::*;
#(
    parameter int               P_GEN_W   = GEN_W,
    parameter int               P_DIV_W   = DIV_W,
    parameter int               P_DIV_MIN = DIV_MIN,
    parameter int               P_PREDIV  = PREDIV,
    parameter logic [P_GEN_W-1:0] P_GEN_RST = GEN_RST,
    parameter logic [P_DIV_W-1:0] P_DIV_RST = DIV_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_we,
    input  logic [P_GEN_W-1:0] gen_wdata,
    input  logic               div_we,
    input  logic [P_DIV_W-1:0] div_wdata,
    input  logic               src_we,
    input  logic               src_wdata,
    output logic               sample_tick,
    output logic               baud_tick
);
    logic [P_GEN_W-1:0] gen_q;
    logic [P_DIV_W-1:0] div_q;
    logic               mode_q;
    logic               div_ok;
    logic               restart;
    logic               src_en;
    logic               wrap;

    // Decide which writes are accepted and whether they restart the chain.
    always_comb begin
        div_ok  = div_we && (div_wdata >= P_DIV_W'(P_DIV_MIN));
        restart = gen_we || div_ok || src_we;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q  <= P_GEN_RST;
            div_q  <= P_DIV_RST;
            mode_q <= 1'b0;
        end else begin
            if (gen_we) gen_q  <= gen_wdata;
            if (div_ok) div_q  <= div_wdata;
            if (src_we) mode_q <= src_wdata;
        end
    end

    baud_prediv #(.PREDIV(P_PREDIV)) u_prediv (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div_mode(mode_q), .src_en(src_en)
    );

    baud_sample_div #(.GEN_W(P_GEN_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .restart(restart), .src_en(src_en),
        .gen(gen_q), .wrap(wrap), .tick(sample_tick)
    );

    baud_bit_div #(.DIV_W(P_DIV_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(wrap),
        .div(div_q), .tick(baud_tick)
    );

    // Every baud tick lines up with a sample tick.
    p_baud_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick);
    // A divider write that is too small leaves the value alone.
    p_div_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_we && !gen_we && !src_we && div_wdata < P_DIV_W'(P_DIV_MIN))
        |=> $stable(div_q));
    // No tick comes out in the cycle after a restart.
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sample_tick && !baud_tick));
endmodule

// File: tb/baud_gen_top_tb_top.sv
// Bench: directed scenarios. Each task checks its own results.
module baud_gen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_we = 1'b0;
    logic [15:0] gen_wdata = '0;
    logic        div_we = 1'b0;
    logic [7:0]  div_wdata = '0;
    logic        src_we = 1'b0;
    logic        src_wdata = 1'b0;
    logic        sample_tick;
    logic        baud_tick;

    int tests = 0;
    int fails = 0;

    baud_gen_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .gen_we(gen_we), .gen_wdata(gen_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .src_we(src_we), .src_wdata(src_wdata),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sample_tick == 1'b0, "R1 sample low in reset", sample_tick, 0);
        check(baud_tick == 1'b0, "R1 baud low in reset", baud_tick, 0);
        rst_n = 1'b1;
    endtask

    task automatic wr_gen(input logic [15:0] v);
        @(negedge clk); gen_we = 1'b1; gen_wdata = v;
        @(negedge clk); gen_we = 1'b0;
    endtask

    task automatic wr_div(input logic [7:0] v);
        @(negedge clk); div_we = 1'b1; div_wdata = v;
        @(negedge clk); div_we = 1'b0;
    endtask

    task automatic wr_src(input logic v);
        @(negedge clk); src_we = 1'b1; src_wdata = v;
        @(negedge clk); src_we = 1'b0;
    endtask

    // Watch one tick. first > 0: the first pulse must be that many cycles
    // after the last write or reset edge. Then the spacing must equal period.
    task automatic measure(input string req, input bit use_baud, input int first,
                           input int period, input int nt);
        int seen = 0;
        int last = 0;
        int lim;
        lim = ((first > 0) ? first : period) + period * nt + 4;
        for (int n = 1; n <= lim && seen < nt; n++) begin
            @(negedge clk);
            if (use_baud && baud_tick && !sample_tick)
                check(1'b0, "R3 baud without sample", 0, 1);
            if (use_baud ? baud_tick : sample_tick) begin
                if (seen == 0) begin
                    if (first > 0) check(n == first, {req, " first tick"}, n, first);
                end else begin
                    check(n - last == period, {req, " period"}, n - last, period);
                end
                seen++;
                last = n;
            end
        end
        check(seen == nt, {req, " tick count"}, seen, nt);
    endtask

    task automatic t_reset_defaults();
        do_reset();
        measure("R1 sample", 1'b0, 651, 651, 2);
        do_reset();
        measure("R1 baud", 1'b1, 10416, 10416, 1);
    endtask

    task automatic t_sample_rate();
        wr_gen(16'd5);
        measure("R2 gen5", 1'b0, 5, 5, 4);
        wr_gen(16'd2);
        measure("R2 gen2", 1'b0, 2, 2, 5);
        @(negedge clk);
        check(sample_tick == 1'b0, "R2 pulse width", sample_tick, 0);
    endtask

    task automatic t_baud_rate();
        wr_div(8'd4);
        wr_gen(16'd3);
        measure("R3 g3d4", 1'b1, 15, 15, 3);
    endtask

    task automatic t_div_reject();
        wr_div(8'd3);
        measure("R5 div3 ignored", 1'b1, -1, 15, 3);
        wr_div(8'd0);
        measure("R5 div0 ignored", 1'b1, -1, 15, 2);
    endtask

    task automatic t_divided_src();
        wr_src(1'b1);
        measure("R6 sample div8", 1'b0, 24, 24, 3);
        wr_gen(16'd3);
        measure("R6 baud div8", 1'b1, 120, 120, 2);
        wr_src(1'b0);
        measure("R6 back to raw", 1'b0, 3, 3, 2);
    endtask

    task automatic t_zero_gen();
        int hits = 0;
        wr_gen(16'd0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sample_tick || baud_tick) hits++;
        end
        check(hits == 0, "R4 zero gen no ticks", hits, 0);
    endtask

    task automatic t_restart();
        wr_gen(16'd9);
        repeat (7) @(negedge clk);
        wr_gen(16'd6);
        measure("R7 gen restart", 1'b0, 6, 6, 2);
        repeat (3) @(negedge clk);
        wr_div(8'd5);
        measure("R7 div restart", 1'b1, 36, 36, 1);
    endtask

    initial begin
        t_reset_defaults();
        t_sample_rate();
        t_baud_rate();
        t_div_reject();
        t_divided_src();
        t_zero_gen();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule